// File: doc/BRIEF.md
# Infrared Run-Length Sampling Receiver

This block turns a demodulated infrared receive line into a stream of run-length code bytes for a processor. On every sampling tick it takes one sample of the line. Runs of equal samples are merged, and each finished run becomes one byte. Bit 7 of the byte holds the level of the run. Bits 6..0 hold the number of samples in the run minus one. The bytes go into a 16-entry receive queue. The processor reads that queue one byte at a time and watches three flags: data ready, overrun and timeout.

Only the period-sampling mode (select code 00) does any work. The other three select codes are accepted but leave the decoder idle. A change into any of those codes also discards a run that is still open.

The run builder is a two-state machine:
- `RUN_IDLE`: no run is open.
- `RUN_OPEN`: a run is being counted.

Its transitions are:
- START (`RUN_IDLE` to `RUN_OPEN`): a tick arrives in period mode. A new run begins with that sample.
- EXTEND (`RUN_OPEN` to `RUN_OPEN`): a tick repeats the current level and the run has fewer than 128 samples. The count goes up by one.
- CLOSE (`RUN_OPEN` to `RUN_OPEN`): a tick brings a new level, or the run already holds 128 samples. The finished run is emitted as a byte, and a new run starts with the current sample.
- ABORT (`RUN_OPEN` to `RUN_IDLE`): the select code leaves 00. The open run is dropped and nothing is emitted.

Top module: `ir_rle_rx`

## Requirements
- R1: After reset, `data_ready`, `overrun` and `timeout` are all 0.
- R2: When `inv_en`=0, a sample with `ir_line`=1 (energy) has level bit 0 and a sample with `ir_line`=0 has level bit 1. When `inv_en`=1, both mappings are reversed. The level sits in bit 7 of each code byte.
- R3: In mode 00, a tick whose level differs from the open run closes that run. The run is pushed as `{level, samples-1}`, with the count in bits 6..0, and the tick's sample starts a new run.
- R4: A run holding 128 equal samples produces no byte until the next tick. That tick pushes `{level, 7'h7F}` and starts a new run with its own sample.
- R5: While `mode_sel` is 01, 10 or 11, no byte is produced. Leaving mode 00 also discards any open run.
- R6: The queue holds 16 bytes in arrival order. `rd_data` shows the oldest byte and `data_ready` is 1 exactly when the queue is not empty. A `data_rd` pulse removes one byte.
- R7: A byte that arrives while the queue is full is dropped, `overrun` is set, and the 16 stored bytes stay intact.
- R8: `timeout` is set on the 32nd tick (4 byte-times of 8 ticks) with no accepted push and no pop while the queue is not empty. Any push, pop or empty queue restarts the count.
- R9: A `stat_rd` pulse clears `overrun` and `timeout`. If a flag's set event falls in the same cycle, the set wins.
- R10: Changes of `ir_line` between ticks have no effect. Only the level present at a tick counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_line | input | 1 | Demodulated infrared line, 1 = energy |
| samp_tick | input | 1 | One-cycle sampling strobe, once per period |
| inv_en | input | 1 | Reverses the level-bit meaning |
| mode_sel | input | 2 | Sampling mode select, 00 = period sampling |
| data_rd | input | 1 | Pops the oldest queued byte |
| stat_rd | input | 1 | Status read, clears overrun and timeout |
| rd_data | output | 8 | Oldest queued code byte, valid when data_ready |
| data_ready | output | 1 | Queue holds at least one byte |
| overrun | output | 1 | A byte was dropped on a full queue |
| timeout | output | 1 | Queue idle for 4 byte-times while not empty |

## Verification
The assertions assume every input is synchronous to `clk` and known after reset. They also assume `samp_tick` is a strobe, so a byte can only follow a cycle in which the strobe was high. The stimulus changes inputs only on falling edges and drives each tick as a single-cycle pulse separated by a low cycle. Mode switches and status reads are timed so that the set-versus-clear collision is reached deliberately rather than by chance.

// File: rtl/ir_rle_pkg.sv
package ir_rle_pkg;

    typedef enum logic [1:0] {
        MODE_TPER      = 2'b00,
        MODE_OVS       = 2'b01,
        MODE_OVS_RSYNC = 2'b10,
        MODE_FIFO_TEST = 2'b11
    } samp_mode_e;

    typedef enum logic {
        RUN_IDLE = 1'b0,
        RUN_OPEN = 1'b1
    } run_state_e;

endpackage

// File: rtl/ir_rle_encoder.sv
module ir_rle_encoder
    import ir_rle_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ir_line,
    input  logic             samp_tick,
    input  logic             inv_en,
    input  logic [1:0]       mode_sel,
    output logic             push_vld,
    output logic [CNT_W:0]   push_byte
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    run_state_e       state_q, state_d;
    logic             lvl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             lvl_now;
    logic             tper;
    logic             close_run;

    // Level bit: 0 means energy unless inverted
    assign lvl_now   = inv_en ? ir_line : ~ir_line;
    assign tper      = (mode_sel == MODE_TPER);
    assign close_run = (state_q == RUN_OPEN) && tper && samp_tick &&
                       ((lvl_now != lvl_q) || (cnt_q == CNT_MAX));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_IDLE: if (tper && samp_tick) state_d = RUN_OPEN;   // START
            RUN_OPEN: if (!tper)             state_d = RUN_IDLE;   // ABORT
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RUN_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            push_vld  <= 1'b0;
            push_byte <= '0;
            lvl_q     <= 1'b0;
            cnt_q     <= '0;
        end else begin
            push_vld <= close_run;
            if (close_run) push_byte <= {lvl_q, cnt_q};           // CLOSE
            if (tper && samp_tick) begin
                if ((state_q == RUN_IDLE) || close_run) begin
                    lvl_q <= lvl_now;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;                         // EXTEND
                end
            end
        end
    end

    assert_push_follows_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push_vld |-> $past(samp_tick));

    assert_idle_modes_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel != MODE_TPER) |=> !push_vld);

endmodule

// File: rtl/ir_rle_fifo.sv
module ir_rle_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         wr_ok,
    output logic         rd_ok,
    output logic         drop
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          full;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign wr_ok   = wr_en && !full;
    assign rd_ok   = rd_en && !empty;
    assign drop    = wr_en && full;
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (rd_ok) rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    assert_drop_keeps_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !rd_ok) |=> (count == FULL_CNT));

endmodule

// File: rtl/ir_rle_status.sv
module ir_rle_status #(
    parameter int TMO_TICKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic samp_tick,
    input  logic wr_ok,
    input  logic rd_ok,
    input  logic empty,
    input  logic drop,
    input  logic stat_rd,
    output logic overrun,
    output logic timeout
);

    localparam int CW = $clog2(TMO_TICKS);
    localparam logic [CW-1:0] LIM = CW'(TMO_TICKS - 1);

    logic [CW-1:0] tmo_cnt;
    logic          restart;
    logic          fire;

    assign restart = wr_ok || rd_ok || empty;
    assign fire    = samp_tick && !restart && (tmo_cnt == LIM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmo_cnt <= '0;
            overrun <= 1'b0;
            timeout <= 1'b0;
        end else begin
            if (restart)        tmo_cnt <= '0;
            else if (samp_tick) tmo_cnt <= (tmo_cnt == LIM) ? '0 : tmo_cnt + 1'b1;

            if (drop)         overrun <= 1'b1;     // set wins over clear
            else if (stat_rd) overrun <= 1'b0;

            if (fire)         timeout <= 1'b1;
            else if (stat_rd) timeout <= 1'b0;
        end
    end

    assert_drop_sets_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> overrun);

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !drop) |=> !overrun);

    assert_timeout_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> $past(samp_tick));

endmodule

// File: rtl/ir_rle_rx.sv
module ir_rle_rx #(
    parameter int CNT_W      = 7,
    parameter int DEPTH      = 16,
    parameter int BYTE_TICKS = 8,
    parameter int TMO_BYTES  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ir_line,
    input  logic             samp_tick,
    input  logic             inv_en,
    input  logic [1:0]       mode_sel,
    input  logic             data_rd,
    input  logic             stat_rd,
    output logic [CNT_W:0]   rd_data,
    output logic             data_ready,
    output logic             overrun,
    output logic             timeout
);

    localparam int W         = CNT_W + 1;
    localparam int TMO_TICKS = TMO_BYTES * BYTE_TICKS;

    logic         push_vld;
    logic [W-1:0] push_byte;
    logic         empty, wr_ok, rd_ok, drop;

    ir_rle_encoder #(.CNT_W(CNT_W)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ir_line   (ir_line),
        .samp_tick (samp_tick),
        .inv_en    (inv_en),
        .mode_sel  (mode_sel),
        .push_vld  (push_vld),
        .push_byte (push_byte)
    );

    ir_rle_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push_vld),
        .wr_data (push_byte),
        .rd_en   (data_rd),
        .rd_data (rd_data),
        .empty   (empty),
        .wr_ok   (wr_ok),
        .rd_ok   (rd_ok),
        .drop    (drop)
    );

    ir_rle_status #(.TMO_TICKS(TMO_TICKS)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp_tick (samp_tick),
        .wr_ok     (wr_ok),
        .rd_ok     (rd_ok),
        .empty     (empty),
        .drop      (drop),
        .stat_rd   (stat_rd),
        .overrun   (overrun),
        .timeout   (timeout)
    );

    assign data_ready = !empty;

    assert_ready_falls_on_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_ready) |-> $past(data_rd));

endmodule

// File: tb/ir_rle_rx_test.sv
module ir_rle_rx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ir_line = 1'b0;
    logic       samp_tick = 1'b0;
    logic       inv_en = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       data_rd = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] rd_data;
    logic       data_ready, overrun, timeout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ir_rle_rx uut (
        .clk(clk), .rst_n(rst_n), .ir_line(ir_line), .samp_tick(samp_tick),
        .inv_en(inv_en), .mode_sel(mode_sel), .data_rd(data_rd), .stat_rd(stat_rd),
        .rd_data(rd_data), .data_ready(data_ready), .overrun(overrun), .timeout(timeout)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [7:0] mq[$];
    bit         m_open = 0, m_lvl = 0, m_pend = 0, m_ovr = 0, m_tmo = 0;
    int         m_cnt = 0, m_tcnt = 0;
    logic [7:0] m_pbyte = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); m_open = 0; m_lvl = 0; m_pend = 0; m_ovr = 0; m_tmo = 0;
            m_cnt = 0; m_tcnt = 0;
        end else begin
            int  sz;
            bit  pop, wr, drp, fire, lv, np;
            logic [7:0] nb;
            sz   = mq.size();
            pop  = data_rd && sz != 0;
            wr   = m_pend && sz != 16;
            drp  = m_pend && sz == 16;
            fire = 0;
            if (wr || pop || sz == 0) m_tcnt = 0;
            else if (samp_tick) begin
                if (m_tcnt == 31) begin fire = 1; m_tcnt = 0; end
                else m_tcnt++;
            end
            if (drp) m_ovr = 1; else if (stat_rd) m_ovr = 0;
            if (fire) m_tmo = 1; else if (stat_rd) m_tmo = 0;
            if (pop) void'(mq.pop_front());
            if (wr) mq.push_back(m_pbyte);
            np = 0; nb = 0;
            lv = inv_en ? ir_line : !ir_line;
            if (mode_sel != 2'b00) m_open = 0;
            else if (samp_tick) begin
                if (!m_open) begin m_open = 1; m_lvl = lv; m_cnt = 0; end
                else if (lv != m_lvl || m_cnt == 127) begin
                    np = 1; nb = {m_lvl, 7'(m_cnt)}; m_lvl = lv; m_cnt = 0;
                end else m_cnt++;
            end
            m_pend = np;
            if (np) m_pbyte = nb;
        end
        #2;
        if (rst_n) begin
            chk(data_ready == (mq.size() != 0), "R6 data_ready vs model", data_ready, mq.size() != 0);
            chk(overrun == m_ovr, "R7 overrun vs model", overrun, m_ovr);
            chk(timeout == m_tmo, "R8 timeout vs model", timeout, m_tmo);
            if (mq.size() != 0)
                chk(rd_data == mq[0], "R3 rd_data vs model", rd_data, mq[0]);
        end
    end

    task automatic sample(input bit l, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ir_line = l; samp_tick = 1'b1;
            @(negedge clk); samp_tick = 1'b0;
        end
    endtask

    task automatic pop_expect(input logic [7:0] exp, input string tag);
        @(negedge clk);
        chk(data_ready === 1'b1 && rd_data === exp, tag, {data_ready, rd_data}, {1'b1, exp});
        data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0;
    endtask

    task automatic abort_run();
        @(negedge clk); mode_sel = 2'b01;
        @(negedge clk); mode_sel = 2'b00;
    endtask

    task automatic stat_pulse();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!data_ready && !overrun && !timeout, "R1 reset flags", {data_ready, overrun, timeout}, 0);

        // R2 / R3: energy runs and level changes
        sample(1, 5); sample(0, 3); sample(1, 1);
        pop_expect(8'h04, "R2 energy run byte");
        pop_expect(8'h82, "R3 no-energy run byte");
        @(negedge clk);
        chk(!data_ready, "R6 queue empty after pops", data_ready, 0);

        // R10: line activity between ticks is ignored
        for (int i = 0; i < 10; i++) begin @(negedge clk); ir_line = i[0]; end
        sample(1, 2); sample(0, 1);
        pop_expect(8'h02, "R10 between-tick toggles ignored");

        // R5: other modes idle
        @(negedge clk); mode_sel = 2'b01;
        sample(0, 3); sample(1, 2);
        mode_sel = 2'b10; sample(0, 2);
        mode_sel = 2'b11; sample(1, 2);
        @(negedge clk);
        chk(!data_ready, "R5 no bytes outside mode 00", data_ready, 0);

        // R2: inversion
        mode_sel = 2'b00; inv_en = 1'b1;
        sample(1, 3); sample(0, 1);
        pop_expect(8'h82, "R2 inverted level");

        // R4: 128-sample cap
        inv_en = 1'b0; abort_run();
        sample(0, 128);
        @(negedge clk);
        chk(!data_ready, "R4 no byte at 128 samples", data_ready, 0);
        sample(0, 1); sample(1, 1);
        pop_expect(8'hFF, "R4 capped run");
        pop_expect(8'h80, "R4 run restarted with current sample");

        // R7 / R9: overrun
        abort_run();
        for (int i = 0; i < 20; i++) sample(!i[0], 1);
        @(negedge clk);
        chk(overrun, "R7 overrun set", overrun, 1);
        stat_pulse(); @(negedge clk);
        chk(!overrun, "R9 status read clears overrun", overrun, 0);
        @(negedge clk); ir_line = 1'b1; samp_tick = 1'b1;
        @(negedge clk); samp_tick = 1'b0; stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
        chk(overrun, "R9 set wins over clear", overrun, 1);
        stat_pulse();
        for (int i = 0; i < 16; i++)
            pop_expect(i[0] ? 8'h80 : 8'h00, "R7 stored bytes kept");
        @(negedge clk);
        chk(!data_ready, "R7 only 16 bytes kept", data_ready, 0);

        // R8: timeout
        sample(0, 1);
        sample(0, 31);
        @(negedge clk);
        chk(!timeout, "R8 no timeout at 31 ticks", timeout, 0);
        sample(0, 1);
        @(negedge clk);
        chk(timeout, "R8 timeout at 32 ticks", timeout, 1);
        stat_pulse(); @(negedge clk);
        chk(!timeout, "R9 status read clears timeout", timeout, 0);
        pop_expect(8'h00, "R8 pending byte");
        sample(0, 40);
        @(negedge clk);
        chk(!timeout, "R8 no timeout when empty", timeout, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R1 actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule